// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio N = 32·M + S. Inside, a prescaler counts either 33 or 32 input cycles per step. A swallow counter keeps it at 33 for the first S steps of each output period. A main counter then ends the period after M steps in total. The ratio therefore comes out as 33·S + 32·(M − S) = 32·M + S. The main count M is legal from 32 to 8191 and the swallow count S from 0 to 31, so N spans 1024 to 262143. For example, M = 437 and S = 16 give N = 14000, which turns a 70 MHz input into a 5 kHz output.

The block gives three outputs:
- a one-cycle pulse at the end of every period;
- a square wave with the same period;
- the prescaler's modulus control.

A load strobe stages new M and S values. A running divider picks them up only at the next period boundary, so no period is ever cut short. When the divider is stopped, staged values take effect at once.

When the enable input is low (power-save or reset upstream), the divider stops and all outputs stay low. When enable returns, a fresh period starts. A main count below 32 can also make S exceed M. Such a main count is clamped to 32 and reported on an error output.

The controller is a three-state machine:
- **IDLE**: the divider is stopped. The staged configuration is committed every cycle. Transitions: *start_swallow* (enable high and S ≠ 0, goes to SWALLOW) and *start_main* (enable high and S = 0, goes to MAIN).
- **SWALLOW**: the prescaler modulus is 33. Transitions: *swallow_done* (prescaler wrap on the last swallow step, goes to MAIN) and *stop* (enable low, goes to IDLE).
- **MAIN**: the prescaler modulus is 32. Transitions: *period_end* (prescaler wrap on the last main step; emits the pulse, reloads the counters and goes to SWALLOW if the new S ≠ 0, otherwise stays in MAIN) and *stop* (enable low, goes to IDLE).

Top module: `dualmod_divider`

## Requirements
- R1: After reset, all outputs are 0, and the active setting is M = 324, S = 4. The first pulse after enable rises therefore N = 10372 cycles after the clock edge that samples enable high.
- R2: While enabled, consecutive rising pulses on `pulse_out` are exactly 32·M + S input cycles apart, for the setting in force.
- R3: `pulse_out` is high for exactly one cycle per period.
- R4: In each period, `modsel_out` (1 = divide by 33, 0 = divide by 32) is high for exactly 33·S cycles, starting in the cycle of the pulse. With S = 0 it stays low all period.
- R5: While `enable` is low, `pulse_out`, `square_out` and `modsel_out` are 0 from the cycle after enable is sampled low.
- R6: A load while running does not change the current period. The period after the next pulse uses the new values.
- R7: A load with M below 32 stores M = 32 and sets `cfg_err` to 1 from the next cycle. A load with M ≥ 32 clears `cfg_err`. Since S ≤ 31, this also covers every case of S > M.
- R8: `square_out` is high in every pulse cycle and falls exactly once per period, so its period equals N.
- R9: A load while disabled is applied when the divider restarts. The first pulse then comes N cycles after the enabling edge, using the loaded N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = run; 0 = stopped (power-save or reset) |
| load | input | 1 | One-cycle strobe that stages `m_in` and `s_in` |
| m_in | input | 13 | Main count M |
| s_in | input | 5 | Swallow count S |
| pulse_out | output | 1 | One-cycle pulse per output period |
| square_out | output | 1 | Square wave with period N |
| modsel_out | output | 1 | Prescaler modulus: 1 = 33, 0 = 32 |
| cfg_err | output | 1 | Last loaded M was below 32 and was clamped |

## Verification
Every cycle, the assertions check the following:
- the one-cycle pulse width;
- the quiet outputs while disabled;
- that the square wave is high in each pulse cycle;
- the clamp flag after each load;
- that no two pulses come closer than the minimum ratio of 1024.

Only the bench scenarios can show that the spacing equals 32·M + S exactly, and that the divide-by-33 window lasts 33·S cycles. The same holds for the boundary handoff of a mid-period load, the S = 0 case and the restart after a load made while stopped.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    // Controller states of the dual-modulus divider.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } dmd_state_e;

endpackage

// File: rtl/dmd_cfg.sv
// Configuration staging: captures a load, clamps an illegal main count,
// and hands the staged values over when the controller commits.
module dmd_cfg #(
    parameter int MW    = 13,
    parameter int SW    = 5,
    parameter int DEF_M = 324,
    parameter int DEF_S = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] m_in,
    input  logic [SW-1:0] s_in,
    input  logic          commit,
    output logic [MW-1:0] sel_m,
    output logic [SW-1:0] sel_s,
    output logic          cfg_err
);

    localparam logic [MW-1:0] M_MIN = MW'(1 << SW);

    logic [MW-1:0] pend_m, act_m, m_fixed;
    logic [SW-1:0] pend_s, act_s;
    logic          pend_v, err_q, m_low;

    assign m_low   = (m_in < M_MIN);
    assign m_fixed = m_low ? M_MIN : m_in;

    // Values that a commit in this cycle would take: a simultaneous load wins.
    always_comb begin
        if (load) begin
            sel_m = m_fixed;
            sel_s = s_in;
        end else if (pend_v) begin
            sel_m = pend_m;
            sel_s = pend_s;
        end else begin
            sel_m = act_m;
            sel_s = act_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_m <= MW'(DEF_M);
            pend_s <= SW'(DEF_S);
            act_m  <= MW'(DEF_M);
            act_s  <= SW'(DEF_S);
            pend_v <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (commit) begin
                act_m  <= sel_m;
                act_s  <= sel_s;
                pend_v <= 1'b0;
            end else if (load) begin
                pend_m <= m_fixed;
                pend_s <= s_in;
                pend_v <= 1'b1;
            end
            if (load) begin
                err_q <= m_low;
            end
        end
    end

    assign cfg_err = err_q;

endmodule

// File: rtl/dmd_prescaler.sv
// Dual-modulus prescaler: counts 2**PLOG or 2**PLOG+1 cycles per step.
module dmd_prescaler #(
    parameter int PLOG = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mod_hi,
    output logic wrap
);

    localparam int CW = PLOG + 1;
    localparam logic [CW-1:0] LIM_LO = CW'((1 << PLOG) - 1);
    localparam logic [CW-1:0] LIM_HI = CW'(1 << PLOG);

    logic [CW-1:0] cnt_q;

    assign wrap = run && (cnt_q == (mod_hi ? LIM_HI : LIM_LO));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/dmd_ctrl.sv
// Swallow/main counting state machine.
module dmd_ctrl
    import dmd_pkg::*;
#(
    parameter int MW = 13,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wrap,
    input  logic [MW-1:0] sel_m,
    input  logic [SW-1:0] sel_s,
    output logic          run,
    output logic          mod_hi,
    output logic          commit,
    output logic          pulse_out,
    output logic          square_out
);

    dmd_state_e    state_q, state_n;
    logic [SW-1:0] sw_q, sw_n;
    logic [MW-1:0] mc_q, mc_n, half_q, half_n;
    logic          pulse_n, pulse_q, sq_q;

    // Next-state and counter logic.
    always_comb begin
        state_n = state_q;
        sw_n    = sw_q;
        mc_n    = mc_q;
        half_n  = half_q;
        pulse_n = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                commit = 1'b1;
                if (enable) begin
                    state_n = (sel_s != '0) ? ST_SWALLOW : ST_MAIN;
                    sw_n    = sel_s;
                    mc_n    = sel_m;
                    half_n  = sel_m >> 1;
                end
            end
            ST_SWALLOW: begin
                if (!enable) begin
                    state_n = ST_IDLE;
                end else if (wrap) begin
                    sw_n = sw_q - SW'(1);
                    mc_n = mc_q - MW'(1);
                    if (sw_q == SW'(1)) begin
                        state_n = ST_MAIN;
                    end
                end
            end
            ST_MAIN: begin
                if (!enable) begin
                    state_n = ST_IDLE;
                end else if (wrap) begin
                    if (mc_q == MW'(1)) begin
                        commit  = 1'b1;
                        pulse_n = 1'b1;
                        state_n = (sel_s != '0) ? ST_SWALLOW : ST_MAIN;
                        sw_n    = sel_s;
                        mc_n    = sel_m;
                        half_n  = sel_m >> 1;
                    end else begin
                        mc_n = mc_q - MW'(1);
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sw_q    <= '0;
            mc_q    <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_n;
            sw_q    <= sw_n;
            mc_q    <= mc_n;
            half_q  <= half_n;
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            sq_q    <= 1'b0;
        end else begin
            pulse_q <= pulse_n;
            sq_q    <= (state_n != ST_IDLE) && (mc_n > half_n);
        end
    end

    assign run        = enable && (state_q != ST_IDLE);
    assign mod_hi     = (state_q == ST_SWALLOW);
    assign pulse_out  = pulse_q;
    assign square_out = sq_q;

endmodule

// File: rtl/dualmod_divider.sv
// Top level: configuration staging, prescaler and controller.
module dualmod_divider #(
    parameter int MW    = 13,
    parameter int SW    = 5,
    parameter int DEF_M = 324,
    parameter int DEF_S = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load,
    input  logic [MW-1:0] m_in,
    input  logic [SW-1:0] s_in,
    output logic          pulse_out,
    output logic          square_out,
    output logic          modsel_out,
    output logic          cfg_err
);

    logic [MW-1:0] sel_m;
    logic [SW-1:0] sel_s;
    logic          commit, run, mod_hi, wrap;

    dmd_cfg #(.MW(MW), .SW(SW), .DEF_M(DEF_M), .DEF_S(DEF_S)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .m_in    (m_in),
        .s_in    (s_in),
        .commit  (commit),
        .sel_m   (sel_m),
        .sel_s   (sel_s),
        .cfg_err (cfg_err)
    );

    dmd_prescaler #(.PLOG(SW)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .mod_hi (mod_hi),
        .wrap   (wrap)
    );

    dmd_ctrl #(.MW(MW), .SW(SW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .wrap       (wrap),
        .sel_m      (sel_m),
        .sel_s      (sel_s),
        .run        (run),
        .mod_hi     (mod_hi),
        .commit     (commit),
        .pulse_out  (pulse_out),
        .square_out (square_out)
    );

    assign modsel_out = mod_hi;

endmodule

// File: rtl/dmd_checker.sv
// Property checker bound to the divider top.
module dmd_checker #(
    parameter int MW = 13,
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          load,
    input logic [MW-1:0] m_in,
    input logic          pulse_out,
    input logic          square_out,
    input logic          modsel_out,
    input logic          cfg_err
);

    localparam logic [MW-1:0] M_MIN = MW'(1 << SW);
    localparam int GW = MW + SW + 1;
    localparam logic [GW-1:0] N_MIN = GW'(1 << (2 * SW));

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!enable) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pulse_out) begin
            gap_q  <= GW'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assert_min_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && seen_q) |-> (gap_q >= N_MIN));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |=> !pulse_out);

    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_out && !square_out && !modsel_out));

    assert_clamp_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (m_in < M_MIN)) |=> cfg_err);

    assert_clamp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (m_in >= M_MIN)) |=> !cfg_err);

    assert_square_at_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> square_out);

endmodule

bind dualmod_divider dmd_checker #(.MW(MW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .load       (load),
    .m_in       (m_in),
    .pulse_out  (pulse_out),
    .square_out (square_out),
    .modsel_out (modsel_out),
    .cfg_err    (cfg_err)
);

// File: tb/dualmod_divider_test.sv
`timescale 1ns/1ps
module dualmod_divider_test;

    logic        clk = 1'b0;
    logic        rst_n, enable, load;
    logic [12:0] m_in;
    logic [4:0]  s_in;
    logic        pulse_out, square_out, modsel_out, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dualmod_divider uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .load       (load),
        .m_in       (m_in),
        .s_in       (s_in),
        .pulse_out  (pulse_out),
        .square_out (square_out),
        .modsel_out (modsel_out),
        .cfg_err    (cfg_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count samples from the enabling edge until the first pulse.
    task automatic wait_first(output int cnt);
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (pulse_out) break;
        end
    endtask

    // Starts on a pulse sample and ends on the next pulse sample.
    task automatic measure(output int len, output int m33, output int falls,
                           output int sq_hi, output int width_ok);
        int prev;
        len = 0; falls = 0;
        m33 = int'(modsel_out);
        sq_hi = int'(square_out);
        prev = int'(square_out);
        width_ok = 1;
        forever begin
            @(negedge clk);
            len++;
            if (len == 1 && pulse_out) width_ok = 0;
            if (pulse_out) break;
            m33 += int'(modsel_out);
            if (prev == 1 && !square_out) falls++;
            prev = int'(square_out);
        end
    endtask

    task automatic check_period(input string tag, input int exp_n, input int exp_m33);
        int len, m33, falls, sq_hi, wok;
        measure(len, m33, falls, sq_hi, wok);
        check({"R2 ", tag}, "period", len, exp_n);
        check({"R4 ", tag}, "divide-by-33 cycles", m33, exp_m33);
        check({"R3 ", tag}, "pulse single cycle", wok, 1);
        check({"R8 ", tag}, "square high at pulse", sq_hi, 1);
        check({"R8 ", tag}, "square falls per period", falls, 1);
    endtask

    task automatic t_reset();
        int hits;
        @(negedge clk);
        check("R1", "pulse after reset", int'(pulse_out), 0);
        check("R1", "square after reset", int'(square_out), 0);
        check("R1", "modsel after reset", int'(modsel_out), 0);
        check("R1", "cfg_err after reset", int'(cfg_err), 0);
        hits = 0;
        repeat (50) begin
            @(negedge clk);
            hits += int'(pulse_out) + int'(square_out) + int'(modsel_out);
        end
        check("R5", "activity while disabled after reset", hits, 0);
    endtask

    task automatic t_default();
        int c;
        enable = 1'b1;
        wait_first(c);
        check("R1", "first pulse with default ratio", c, 10373);
        check_period("default M=324 S=4", 10372, 132);
    endtask

    task automatic t_off_and_reload();
        int hits, c;
        repeat (500) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i == 1000) begin
                load = 1'b1; m_in = 13'd437; s_in = 5'd16;
            end else begin
                load = 1'b0;
            end
            hits += int'(pulse_out) + int'(square_out) + int'(modsel_out);
        end
        check("R5", "outputs while disabled", hits, 0);
        check("R7", "cfg_err after legal load", int'(cfg_err), 0);
        enable = 1'b1;
        wait_first(c);
        check("R9", "first pulse after reload while off", c, 14001);
        check_period("M=437 S=16", 14000, 528);
    endtask

    // Called on a pulse sample: loads mid-period and checks the handoff.
    task automatic t_midload(input string tag, input int m, input int s,
                             input int exp_old, input int exp_new,
                             input int exp_m33, input int exp_err);
        int cnt;
        cnt = 0;
        repeat (100) begin
            @(negedge clk);
            cnt++;
        end
        load = 1'b1; m_in = 13'(m); s_in = 5'(s);
        @(negedge clk);
        cnt++;
        load = 1'b0;
        check({"R7 ", tag}, "cfg_err after load", int'(cfg_err), exp_err);
        while (!pulse_out) begin
            @(negedge clk);
            cnt++;
        end
        check({"R6 ", tag}, "period containing the load", cnt, exp_old);
        check_period(tag, exp_new, exp_m33);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0; load = 1'b0; m_in = '0; s_in = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default();
        t_off_and_reload();
        t_midload("M=40 S=5", 40, 5, 14000, 1285, 165, 0);
        t_midload("R4 S=0 M=33", 33, 0, 1285, 1056, 0, 0);
        t_midload("clamp M=10 S=20", 10, 20, 1056, 1044, 660, 1);
        t_midload("legal M=50 S=3", 50, 3, 1044, 1603, 99, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule